// File: doc/BRIEF.md
# Filtered Power-On Reset Generator

This block produces the active-low system reset from a digital supply-good indication. A comparator outside the block raises `below_async_i` whenever the logic supply is under its reset threshold. The block brings that signal into the clock domain, keeps reset asserted while the supply is bad, and releases reset only after a fixed number of slow cycle-time ticks has been counted on `tick_i` with the supply continuously good.

Once the system is running, a supply dip must last longer than a reaction-time filter, counted in system clocks, before it counts as a power-down. Shorter dips leave the output alone. A qualified power-down asserts reset, emits a one-clock pulse that downstream watchdog and enable logic use to clear themselves, and forces the whole release delay to run again. A watchdog request can pull reset low at any time while the system is running.

Top module: `por_reset_gen`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_n_o` is 0 and `pd_pulse_o` is 0, and after `rst_ni` rises reset stays asserted until a full release delay has completed.
- R2: `below_async_i` passes through `SYNC_STAGES` flip-flops (default 2) before any logic uses it. While its synchronized value is 1 and the system is not running, `sys_rst_n_o` stays 0, and ticks are not counted.
- R3: With the synchronized supply good, `sys_rst_n_o` goes to 1 in the cycle after the clock edge that samples the `DELAY_TICKS`-th `tick_i` pulse. Ticks seen before the supply turned good do not count.
- R4: While running, a synchronized dip lasting at most `FILTER_CLKS` consecutive clocks changes neither `sys_rst_n_o` nor `pd_pulse_o`.
- R5: While running, a synchronized dip lasting `FILTER_CLKS`+1 consecutive clocks or more drives `sys_rst_n_o` to 0 and produces exactly one `pd_pulse_o` pulse, one clock wide.
- R6: After a qualified power-down, release requires a fresh run of `DELAY_TICKS` ticks counted from the moment the supply is good again.
- R7: A synchronized dip of any length during the release delay abandons the count at once, with no power-down pulse; the full `DELAY_TICKS` must be counted again afterwards.
- R8: While running, `wd_req_i` = 1 forces `sys_rst_n_o` to 0 in the same cycle for as long as it is held, and on its removal reset releases at once without a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low global reset |
| tick_i | input | 1 | One-clock strobe per cycle-time tick |
| below_async_i | input | 1 | Supply under threshold, asynchronous, active high |
| wd_req_i | input | 1 | Watchdog reset request, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| pd_pulse_o | output | 1 | One-clock pulse on a qualified power-down |

## Verification
A change on `below_async_i` reaches the control state after two clocks of synchronization plus one state register, so the bench waits at least four clock periods after a supply edge before expecting a state change, and measures dip lengths in clocks of held input, which the synchronizer preserves one for one. Release is due at the first negative edge after the edge that samples the last tick, and the bench checks low after the next-to-last tick and high right after the last. The watchdog path is combinational to the output, so that check samples one nanosecond after the request changes. Dip lengths are swept from one clock to two beyond the filter length, with the expected outcome and pulse count computed from that length against `FILTER_CLKS`.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    POR_HOLD  = 2'd0,
    POR_DELAY = 2'd1,
    POR_RUN   = 2'd2
  } por_state_e;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  // resets to 1: supply treated as bad until proven good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/por_dip_filter.sv
module por_dip_filter #(
  parameter int FILTER_CLKS = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic below_i,
  output logic qualify_o
);
  localparam int FW = (FILTER_CLKS < 1) ? 1 : $clog2(FILTER_CLKS + 1);
  localparam logic [FW-1:0] FLIM = FW'(FILTER_CLKS);

  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !below_i) cnt_q <= '0;
    else if (cnt_q != FLIM)     cnt_q <= cnt_q + 1'b1;
  end

  // fires on the (FILTER_CLKS+1)-th consecutive low-supply clock
  assign qualify_o = en_i & below_i & (cnt_q == FLIM);
endmodule

// File: rtl/por_delay_ctr.sv
module por_delay_ctr #(
  parameter int DELAY_TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int DW = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [DW-1:0] DLIM = DW'(DELAY_TICKS - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i & tick_i & (cnt_q == DLIM);
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen
  import por_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_TICKS = 64,
  parameter int FILTER_CLKS = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic below_async_i,
  input  logic wd_req_i,
  output logic sys_rst_n_o,
  output logic pd_pulse_o
);
  por_state_e state_q, state_d;
  logic below_s;
  logic delay_en, delay_done;
  logic filt_en, qualify;
  logic pd_q;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (below_async_i),
    .q_o    (below_s)
  );

  assign delay_en = (state_q == POR_DELAY) & ~below_s;
  assign filt_en  = (state_q == POR_RUN);

  por_delay_ctr #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (delay_en),
    .tick_i (tick_i),
    .done_o (delay_done)
  );

  por_dip_filter #(.FILTER_CLKS(FILTER_CLKS)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (filt_en),
    .below_i   (below_s),
    .qualify_o (qualify)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      POR_HOLD:  if (!below_s) state_d = POR_DELAY;
      POR_DELAY: begin
        if (below_s)         state_d = POR_HOLD;
        else if (delay_done) state_d = POR_RUN;
      end
      POR_RUN:   if (qualify) state_d = POR_HOLD;
      default:   state_d = POR_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= POR_HOLD;
      pd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pd_q    <= qualify;
    end
  end

  assign sys_rst_n_o = (state_q == POR_RUN) & ~wd_req_i;
  assign pd_pulse_o  = pd_q;
endmodule

// File: rtl/por_reset_gen_chk.sv
module por_reset_gen_chk
  import por_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wd_req_i,
  input logic       sys_rst_n_o,
  input logic       pd_pulse_o,
  input por_state_e state_q,
  input logic       below_s
);
  assert_release_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == POR_RUN && $past(state_q) != POR_RUN) |-> ($past(tick_i) && $past(state_q) == POR_DELAY && !$past(below_s)));

  assert_exit_only_qualified_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == POR_RUN && state_q != POR_RUN) |-> pd_pulse_o);

  assert_pulse_one_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_pulse_o |=> !pd_pulse_o);

  assert_pulse_from_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_pulse_o |-> (state_q == POR_HOLD && $past(state_q) == POR_RUN));

  assert_delay_abandon_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == POR_DELAY && below_s) |=> (state_q == POR_HOLD && !pd_pulse_o));

  assert_wd_forces_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_req_i |-> !sys_rst_n_o);

  assert_low_while_bad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_s && state_q != POR_RUN) |-> !sys_rst_n_o);
endmodule

bind por_reset_gen por_reset_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wd_req_i    (wd_req_i),
  .sys_rst_n_o (sys_rst_n_o),
  .pd_pulse_o  (pd_pulse_o),
  .state_q     (state_q),
  .below_s     (below_s)
);

// File: tb/por_reset_gen_bench.sv
`timescale 1ns/1ps
module por_reset_gen_bench;
  localparam int D = 8;
  localparam int F = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic below = 1'b1;
  logic wd = 1'b0;
  logic rst_n_o, pd_o;

  int n_run = 0, n_fail = 0, pd_cnt = 0, dbl_cnt = 0;
  logic pd_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  por_reset_gen #(.SYNC_STAGES(2), .DELAY_TICKS(D), .FILTER_CLKS(F)) u_por_reset_gen (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .below_async_i (below),
    .wd_req_i      (wd),
    .sys_rst_n_o   (rst_n_o),
    .pd_pulse_o    (pd_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (pd_o) pd_cnt++;
      if (pd_o && pd_prev) dbl_cnt++;
      pd_prev <= pd_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic release_seq(input string req);
    for (int i = 0; i < D - 1; i++) tick_once();
    check(rst_n_o == 1'b0, req, rst_n_o, 0);
    tick_once();
    check(rst_n_o == 1'b1, req, rst_n_o, 1);
  endtask

  task automatic dip(input int n);
    @(negedge clk) below = 1'b1;
    repeat (n) @(negedge clk);
    below = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rst_n_o == 1'b0, "R1", rst_n_o, 0);
    check(pd_o == 1'b0, "R1", pd_o, 0);
    rst_ni = 1'b1;

    // R2: supply bad, ticks must not count
    for (int i = 0; i < 2 * D; i++) tick_once();
    check(rst_n_o == 1'b0, "R2", rst_n_o, 0);

    below = 1'b0;
    repeat (4) @(negedge clk);
    release_seq("R3");

    // R8: watchdog request while running
    @(negedge clk) wd = 1'b1;
    #1 check(rst_n_o == 1'b0, "R8", rst_n_o, 0);
    repeat (3) @(negedge clk);
    #1 check(rst_n_o == 1'b0, "R8", rst_n_o, 0);
    @(negedge clk) wd = 1'b0;
    #1 check(rst_n_o == 1'b1, "R8", rst_n_o, 1);

    // R4/R5/R6: sweep dip length
    for (int n = 1; n <= F + 2; n++) begin
      int base;
      bit qual;
      base = pd_cnt;
      qual = (n > F);
      dip(n);
      repeat (n + 5) @(negedge clk);
      if (qual) begin
        check(rst_n_o == 1'b0, "R5", rst_n_o, 0);
        check(pd_cnt - base == 1, "R5", pd_cnt - base, 1);
        release_seq("R6");
      end else begin
        check(rst_n_o == 1'b1, "R4", rst_n_o, 1);
        check(pd_cnt - base == 0, "R4", pd_cnt - base, 0);
      end
    end

    // R7: drop during delay abandons the count
    begin
      int base;
      base = pd_cnt;
      dip(F + 2);
      repeat (F + 7) @(negedge clk);
      for (int i = 0; i < 3; i++) tick_once();
      dip(1);
      repeat (5) @(negedge clk);
      release_seq("R7");
      check(pd_cnt - base == 1, "R7", pd_cnt - base, 1);
    end

    check(dbl_cnt == 0, "R5", dbl_cnt, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule